// File: doc/BRIEF.md
# Keyed-Write Watchdog Timer

This block is a small watchdog peripheral. It has an 8-bit up-counter clocked through a power-of-two prescaler and a control/status byte. Software writes both registers with 16-bit bus writes. A write lands only when its high byte carries the key that belongs to the addressed register. Any other write is dropped without a trace, so a stray store cannot disturb the timer. Both registers read back as single bytes.

In watchdog mode, a counter wrap from all-ones to zero sets a sticky watchdog flag and emits a one-cycle reset request. In interval mode, the same wrap sets a sticky interval flag instead, and the interrupt output follows that flag. Software keeps the watchdog alive by reloading the counter with zero before it wraps. It also clears the interval flag with a keyed control write. The counter advances only while the enable bit is set, and disabling it freezes the count.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the control byte reads 0x00, the counter reads 0x00, and both rst_req and irq are low.
- R2: A write to the counter address loads bits 7..0 into the counter only when bits 15..8 equal 0x5A. Any other high byte, including 0xA5, leaves the counter unchanged.
- R3: A write to the control address loads the control byte only when bits 15..8 equal 0xA5. Any other high byte leaves every control bit unchanged.
- R4: The control byte is laid out as bit 7 enable, bit 6 mode (1 = watchdog, 0 = interval), bit 5 reset kind, bit 4 watchdog flag, bit 3 interval flag, and bits 2..0 divider code. While enabled, the counter steps by one every 2^(5+code) clock cycles, from divide-by-32 at code 0 to divide-by-4096 at code 7.
- R5: While the enable bit is 0, the counter holds its value.
- R6: In watchdog mode, the clock edge that wraps the counter from 0xFF to 0x00 also sets bit 4. rst_req is then high for exactly the one following cycle, and irq is not raised.
- R7: In interval mode, the wrap sets bit 3. irq stays high until bit 3 is cleared, and rst_req stays low.
- R8: Both flags are sticky. A keyed control write of 0 clears a flag, and a keyed control write of 1 cannot set one.
- R9: Reloading the counter with 0 before it reaches 0xFF prevents any reset request, for as long as the reloads continue.
- R10: The reset-kind bit 5 is stored and read back unchanged, and it does not affect counting.
- R11: A new divider code written while the timer runs is used from the next prescaler tick onward, with no stray counter step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register address (counter or control) |
| bus_wdata | input | 16 | Write data: key in 15..8, value in 7..0 |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 8 | Read data for the addressed register |
| rst_req | output | 1 | One-cycle reset request on a watchdog wrap |
| irq | output | 1 | Interval-mode interrupt (mirrors the interval flag) |

## Verification
The key check sends writes that carry the correct key, a wrong key, and the other register's key to each address. This separates real key decoding from address-only decoding. Counting rate is measured over windows that are exact multiples of the tick period, at three divider codes and across a code change made mid-run. This separates correct scaling from off-by-one or stale-code prescalers. Wraps are placed on exact cycles in both modes, so a mode swap, a missing flag or a reset pulse of the wrong length is visible. A long serviced run shows that reloading the counter really holds off the reset request.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    localparam logic [7:0] KEY_CNT = 8'h5A;
    localparam logic [7:0] KEY_CSR = 8'hA5;

    // bit positions are software-visible: 7 en, 6 mode, 5 kind, 4 wflag, 3 iflag, 2..0 code
    typedef struct packed {
        logic       en;
        logic       wdt_mode;
        logic       rst_kind;
        logic       wflag;
        logic       iflag;
        logic [2:0] code;
    } ctl_t;
endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
    parameter int BASE_LOG2 = 5,
    parameter int SEL_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] code,
    output logic             tick
);
    localparam int PRE_W = BASE_LOG2 + (1 << SEL_W) - 1;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_st_t;

    pre_st_t          st_d, st_q;
    logic [PRE_W-1:0] mask;

    always_comb begin
        for (int i = 0; i < PRE_W; i++) begin
            mask[i] = (i < (BASE_LOG2 + int'(code)));
        end
        tick = run && ((st_q.pre & mask) == mask);
        st_d = st_q;
        if (run) begin
            st_d.pre = st_q.pre + PRE_W'(1);
        end else begin
            st_d.pre = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        wrap = 1'b0;
        if (load) begin
            st_d.cnt = load_val;
        end else if (tick) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
            wrap     = (st_q.cnt == {CNT_W{1'b1}});
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;
endmodule

// File: rtl/wdg_ctl.sv
module wdg_ctl
    import wdg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [7:0] wr_byte,
    input  logic       wrap,
    output ctl_t       ctl,
    output logic       rst_pulse,
    output logic       irq
);
    typedef struct packed {
        ctl_t ctl;
        logic rst;
    } ctl_st_t;

    ctl_st_t st_d, st_q;
    ctl_t    wv;

    always_comb begin
        wv   = ctl_t'(wr_byte);
        st_d = st_q;
        st_d.rst = 1'b0;
        if (wr) begin
            st_d.ctl.en       = wv.en;
            st_d.ctl.wdt_mode = wv.wdt_mode;
            st_d.ctl.rst_kind = wv.rst_kind;
            st_d.ctl.code     = wv.code;
            // flags may only be cleared by software
            st_d.ctl.wflag    = st_q.ctl.wflag & wv.wflag;
            st_d.ctl.iflag    = st_q.ctl.iflag & wv.iflag;
        end
        if (wrap) begin
            if (st_q.ctl.wdt_mode) begin
                st_d.ctl.wflag = 1'b1;
                st_d.rst       = 1'b1;
            end else begin
                st_d.ctl.iflag = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl       = st_q.ctl;
    assign rst_pulse = st_q.rst;
    assign irq       = st_q.ctl.iflag;
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import wdg_pkg::*;
#(
    parameter int          ADDR_W    = 2,
    parameter int          CNT_W     = 8,
    parameter int          BASE_LOG2 = 5,
    parameter logic [ADDR_W-1:0] CNT_ADDR = ADDR_W'(0),
    parameter logic [ADDR_W-1:0] CSR_ADDR = ADDR_W'(1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    input  logic              bus_we,
    output logic [7:0]        bus_rdata,
    output logic              rst_req,
    output logic              irq
);
    localparam int SEL_W = 3;

    logic             cnt_wr, csr_wr, tick, wrap;
    logic [CNT_W-1:0] cnt_val;
    ctl_t             ctl;
    logic [7:0]       csr_byte;

    assign cnt_wr = bus_we && (bus_addr == CNT_ADDR) && (bus_wdata[15:8] == KEY_CNT);
    assign csr_wr = bus_we && (bus_addr == CSR_ADDR) && (bus_wdata[15:8] == KEY_CSR);

    wdg_prescaler #(
        .BASE_LOG2(BASE_LOG2),
        .SEL_W    (SEL_W)
    ) i_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (ctl.en),
        .code (ctl.code),
        .tick (tick)
    );

    wdg_counter #(
        .CNT_W(CNT_W)
    ) i_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .load    (cnt_wr),
        .load_val(bus_wdata[CNT_W-1:0]),
        .cnt     (cnt_val),
        .wrap    (wrap)
    );

    wdg_ctl i_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (csr_wr),
        .wr_byte  (bus_wdata[7:0]),
        .wrap     (wrap),
        .ctl      (ctl),
        .rst_pulse(rst_req),
        .irq      (irq)
    );

    assign csr_byte = ctl;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CNT_ADDR) begin
            bus_rdata = 8'(cnt_val);
        end else if (bus_addr == CSR_ADDR) begin
            bus_rdata = csr_byte;
        end
    end
endmodule

// File: rtl/wdg_checker.sv
module wdg_checker
    import wdg_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int CNT_W  = 8,
    parameter logic [ADDR_W-1:0] CNT_ADDR = ADDR_W'(0),
    parameter logic [ADDR_W-1:0] CSR_ADDR = ADDR_W'(1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [15:0]       bus_wdata,
    input logic              bus_we,
    input logic              rst_req,
    input logic              irq,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [7:0]        csr_q
);
    logic cnt_key_ok, csr_bad_key;
    assign cnt_key_ok  = bus_we && (bus_addr == CNT_ADDR) && (bus_wdata[15:8] == 8'h5A);
    assign csr_bad_key = bus_we && (bus_addr == CSR_ADDR) && (bus_wdata[15:8] != 8'hA5);

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_key_ok |=> cnt_q == $past(bus_wdata[CNT_W-1:0]));

    p_badkey_r3: assert property (@(posedge clk) disable iff (!rst_n)
        csr_bad_key |=> {csr_q[7:5], csr_q[2:0]} == $past({csr_q[7:5], csr_q[2:0]}));

    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_key_ok |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CNT_W'(1)));

    p_halt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!csr_q[7] && !cnt_key_ok) |=> cnt_q == $past(cnt_q));

    p_rst_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    p_rst_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> csr_q[4] && $past(csr_q[6]) && ($past(cnt_q) == {CNT_W{1'b1}}));

    p_irq_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> !$past(csr_q[6]) && $past(csr_q[7]) && ($past(cnt_q) == {CNT_W{1'b1}}));

    p_wflag_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(csr_q[4]) |-> $past(csr_q[6]) && $past(csr_q[7]) && ($past(cnt_q) == {CNT_W{1'b1}}));
endmodule

bind keyed_watchdog wdg_checker #(
    .ADDR_W  (ADDR_W),
    .CNT_W   (CNT_W),
    .CNT_ADDR(CNT_ADDR),
    .CSR_ADDR(CSR_ADDR)
) i_wdg_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_we   (bus_we),
    .rst_req  (rst_req),
    .irq      (irq),
    .cnt_q    (cnt_val),
    .csr_q    (csr_byte)
);

// File: tb/test_keyed_watchdog.sv
module test_keyed_watchdog;
    localparam logic [1:0] A_CNT = 2'd0;
    localparam logic [1:0] A_CSR = 2'd1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_rdata;
    logic        rst_req, irq;

    int errors = 0;
    int checks = 0;
    int rst_pulses = 0;
    bit done = 0;

    always #10 clk = ~clk;

    keyed_watchdog i_keyed_watchdog (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_we   (bus_we),
        .bus_rdata(bus_rdata),
        .rst_req  (rst_req),
        .irq      (irq)
    );

    always @(negedge clk) if (rst_n && rst_req) rst_pulses++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    // call while already at a negedge
    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        @(negedge clk);
        rd(A_CSR, v); chk("R1 ctl", v, 8'h00);
        rd(A_CNT, v); chk("R1 cnt", v, 8'h00);
        chk("R1 rst_req", rst_req, 0);
        chk("R1 irq", irq, 0);
    endtask

    task automatic t_keys();
        logic [7:0] v;
        wr(A_CNT, 16'h5A33); rd(A_CNT, v); chk("R2 good key", v, 8'h33);
        wr(A_CNT, 16'h5B44); rd(A_CNT, v); chk("R2 wrong key", v, 8'h33);
        wr(A_CNT, 16'hA577); rd(A_CNT, v); chk("R2 ctl key on cnt", v, 8'h33);
        wr(A_CSR, 16'hA525); rd(A_CSR, v); chk("R10 kind bit stored", v, 8'h25);
        wr(A_CSR, 16'h5A07); rd(A_CSR, v); chk("R3 cnt key on ctl", v, 8'h25);
        wr(A_CSR, 16'h00C0); rd(A_CSR, v); chk("R3 zero key", v, 8'h25);
        rd(A_CNT, v); chk("R5 disabled holds", v, 8'h33);
        wr(A_CSR, 16'hA500);
    endtask

    task automatic t_rate();
        logic [7:0] a, b;
        wr(A_CNT, 16'h5A00);
        wr(A_CSR, 16'hA5A0);                // enabled, interval, kind set, code 0
        rd(A_CNT, a); repeat (320) @(posedge clk); @(negedge clk); rd(A_CNT, b);
        chk("R4 div32 rate", 8'(b - a), 10);
        chk("R10 kind no effect", 8'(b - a), 10);
        wr(A_CSR, 16'hA582);                // switch to div128 while running
        rd(A_CNT, a); repeat (640) @(posedge clk); @(negedge clk); rd(A_CNT, b);
        chk("R11 switch to div128", 8'(b - a), 5);
        wr(A_CSR, 16'hA587);
        rd(A_CNT, a); repeat (8192) @(posedge clk); @(negedge clk); rd(A_CNT, b);
        chk("R4 div4096 rate", 8'(b - a), 2);
        wr(A_CSR, 16'hA507);
        rd(A_CNT, a); repeat (500) @(posedge clk); @(negedge clk); rd(A_CNT, b);
        chk("R5 halted count kept", b, a);
        chk("R7 no wrap yet", irq, 0);
    endtask

    task automatic t_wdt();
        logic [7:0] v;
        int p0;
        wr(A_CNT, 16'h5AFC);
        p0 = rst_pulses;
        wr(A_CSR, 16'hA5C0);                // enable, watchdog, div32
        repeat (127) @(posedge clk); @(negedge clk);
        rd(A_CNT, v); chk("R6 before wrap cnt", v, 8'hFF);
        chk("R6 before wrap rst_req", rst_req, 0);
        @(posedge clk); @(negedge clk);
        chk("R6 rst_req on wrap", rst_req, 1);
        rd(A_CSR, v); chk("R6 wflag set", v, 8'hD0);
        rd(A_CNT, v); chk("R6 cnt wrapped", v, 8'h00);
        chk("R6 no irq", irq, 0);
        @(negedge clk);
        chk("R6 pulse one cycle", rst_req, 0);
        chk("R6 pulse count", rst_pulses - p0, 1);
        wr(A_CSR, 16'hA5D0); rd(A_CSR, v); chk("R8 write 1 keeps flag", v, 8'hD0);
        wr(A_CSR, 16'hA540); rd(A_CSR, v); chk("R8 write 0 clears", v, 8'h40);
        wr(A_CSR, 16'hA550); rd(A_CSR, v); chk("R8 write 1 no set", v, 8'h40);
    endtask

    task automatic t_irq();
        logic [7:0] v;
        int p0;
        wr(A_CNT, 16'h5AFE);
        p0 = rst_pulses;
        wr(A_CSR, 16'hA581);                // enable, interval, div64
        repeat (127) @(posedge clk); @(negedge clk);
        chk("R7 irq before wrap", irq, 0);
        @(posedge clk); @(negedge clk);
        chk("R7 irq on wrap", irq, 1);
        rd(A_CSR, v); chk("R7 iflag set", v, 8'h89);
        repeat (10) @(posedge clk); @(negedge clk);
        chk("R7 irq held", irq, 1);
        chk("R7 no rst_req", rst_pulses - p0, 0);
        wr(A_CSR, 16'hA501); rd(A_CSR, v); chk("R8 iflag cleared", v, 8'h01);
        chk("R7 irq drops", irq, 0);
        wr(A_CSR, 16'hA509); rd(A_CSR, v); chk("R8 iflag not set by 1", v, 8'h01);
        chk("R8 irq stays low", irq, 0);
    endtask

    task automatic t_service();
        logic [7:0] v;
        int p0;
        wr(A_CNT, 16'h5A00);
        p0 = rst_pulses;
        wr(A_CSR, 16'hA5C0);
        for (int k = 0; k < 4; k++) begin
            repeat (6000) @(posedge clk);
            wr(A_CNT, 16'h5A00);
            wr(A_CSR, 16'hA5C0);
        end
        @(negedge clk);
        chk("R9 no reset while serviced", rst_pulses - p0, 0);
        rd(A_CSR, v); chk("R9 no wflag", v, 8'hC0);
        wr(A_CSR, 16'hA540);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_keys();
        t_rate();
        t_wdt();
        t_irq();
        t_service();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule